// File: doc/BRIEF.md
# Reload Down-Counter Timer with Coherent Byte Reads

This block is a 16-bit down-counter with a reload register. It sits behind an 8-bit register interface. Software writes the reload value one byte at a time. A start pulse, given while count enable is high, copies the reload value into the counter. After that load, the counter decrements once per clock for as long as count enable stays high. When the counter is at zero, the next step reloads it and raises an underflow pulse. In reload mode counting then continues. In one-shot mode the counter stops and keeps the reloaded value.

Software can read the running count at any time. A high-byte read stores the low byte of the same cycle in a shadow latch, and the next low-byte read returns that stored byte. This keeps the two halves coherent even while the counter is moving. A word read returns the whole count from a single cycle.

The count-read path and the reload-write path share the same pair of byte addresses. A write at either address therefore changes only the reload register and never the running count.

Top module: `reload_timer16`

## Requirements
- R1: During and after reset, the count, the reload register, the shadow latch, `rd_data` and `underflow` are all zero.
- R2: A `start` pulse while `run_en` is 1 loads the reload value into the count at the next edge. Each later cycle with `run_en` at 1 lowers the count by one.
- R3: A write with `bus_addr`=1 sets reload bits [15:8], and a write with `bus_addr`=0 sets reload bits [7:0], both effective from the next cycle. A write never changes the running count.
- R4: A byte read with `bus_addr`=1 returns count bits [15:8] on `rd_data[7:0]`, with `rd_data[15:8]`=0, one cycle after the strobe. It also stores count bits [7:0] of that same cycle in the shadow latch. A following byte read with `bus_addr`=0 returns that stored byte.
- R5: A low-byte read that does not follow a fresh high-byte read returns the shadow latch as it stands, not the live low byte.
- R6: A read with `bus_word`=1 returns the full 16-bit count of the strobe cycle on `rd_data` one cycle later. The address bit is ignored for word reads.
- R7: A running, enabled count at zero is replaced by the reload value at the next edge, and `underflow` is 1 for exactly that cycle. With `oneshot`=0, counting continues afterwards.
- R8: With `oneshot`=1, counting stops after the underflow reload. The count then holds the reload value until the next start.
- R9: While `run_en` is 0 the count holds its value, and a `start` pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Byte select: 1 = high byte, 0 = low byte |
| bus_word | input | 1 | Read the full 16-bit count in one access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (reload register) |
| bus_wdata | input | 8 | Write data byte |
| rd_data | output | 16 | Read data, valid one cycle after the read strobe |
| run_en | input | 1 | Count enable |
| start | input | 1 | Start pulse: load reload value and begin counting |
| oneshot | input | 1 | 1 = stop after underflow, 0 = keep reloading |
| underflow | output | 1 | One-cycle pulse on the underflow reload |

## Verification
Read results appear on `rd_data` one edge after the read strobe. The driver pushes each expected value into a queue as it raises the strobe. The monitor pops and compares one cycle later, between edges, using a delayed copy of the strobe to know when a result is due. The expected values come from a cycle model built from the requirements. Reload writes, start loads and underflow reloads all take effect at the edge after their cause. The model updates on that same edge, and `underflow` is compared against it in the middle of every cycle.

// File: rtl/reload_timer16.sv
module reload_timer16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_addr,
  input  logic        bus_word,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [15:0] rd_data,
  input  logic        run_en,
  input  logic        start,
  input  logic        oneshot,
  output logic        underflow
);

  logic [15:0] cnt;
  logic [15:0] reload;
  logic [7:0]  shadow;
  logic        running;

  wire go      = start && run_en;
  wire step    = running && run_en && !go;
  wire at_zero = (cnt == 16'h0000);
  wire rd_hi   = bus_rd && !bus_word && bus_addr;
  wire rd_lo   = bus_rd && !bus_word && !bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (bus_wr) begin
      if (bus_addr) reload[15:8] <= bus_wdata;
      else          reload[7:0]  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      running   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      underflow <= 1'b0;
      if (go) begin
        cnt     <= reload;
        running <= 1'b1;
      end else if (step) begin
        if (at_zero) begin
          cnt       <= reload;
          underflow <= 1'b1;
          if (oneshot) running <= 1'b0;
        end else begin
          cnt <= cnt - 16'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow  <= '0;
      rd_data <= '0;
    end else if (bus_rd) begin
      if (bus_word) begin
        rd_data <= cnt;
      end else if (bus_addr) begin
        rd_data <= {8'h00, cnt[15:8]};
        shadow  <= cnt[7:0];
      end else begin
        rd_data <= {8'h00, shadow};
      end
    end
  end

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (cnt == $past(reload) && running)); // R2
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero) |=> (cnt == $past(cnt) - 16'd1)); // R2
  AST_WR_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> (reload[15:8] == $past(bus_wdata))); // R3
  AST_WR_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> (reload[7:0] == $past(bus_wdata))); // R3
  AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (shadow == $past(cnt[7:0]) && rd_data[15:8] == 8'h00)); // R4
  AST_LO_FROM_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> (rd_data == {8'h00, $past(shadow)})); // R5
  AST_WORD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_word) |=> (rd_data == $past(cnt))); // R6
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero) |=> (underflow && cnt == $past(reload))); // R7
  AST_UF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(step && at_zero)) |=> !underflow); // R7
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && oneshot) |=> !running); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(cnt)); // R9

endmodule

// File: tb/test_reload_timer16.sv
`timescale 1ns/1ps
module test_reload_timer16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0, bus_word = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] rd_data;
  logic        run_en = 1'b0, start = 1'b0, oneshot = 1'b0;
  logic        underflow;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  reload_timer16 i_reload_timer16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_word(bus_word),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .run_en(run_en), .start(start), .oneshot(oneshot), .underflow(underflow)
  );

  // cycle model built from the requirements
  logic [15:0] m_cnt, m_rel;
  logic [7:0]  m_sh;
  logic        m_run, m_uf, rd_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_rel <= '0; m_sh <= '0; m_run <= 0; m_uf <= 0; rd_q <= 0;
    end else begin
      rd_q <= bus_rd;
      m_uf <= 0;
      if (bus_wr) begin
        if (bus_addr) m_rel[15:8] <= bus_wdata;
        else          m_rel[7:0]  <= bus_wdata;
      end
      if (start && run_en) begin
        m_cnt <= m_rel; m_run <= 1;
      end else if (m_run && run_en) begin
        if (m_cnt == 0) begin
          m_cnt <= m_rel; m_uf <= 1;
          if (oneshot) m_run <= 0;
        end else m_cnt <= m_cnt - 1;
      end
      if (bus_rd && !bus_word && bus_addr) m_sh <= m_cnt[7:0];
    end
  end

  logic [15:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: read results due one edge after the strobe; underflow every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rd_q) begin
        if (exp_q.size() == 0) check("scoreboard-empty", 16'hxxxx, 16'h0);
        else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
      check("R7 underflow", {15'h0, underflow}, {15'h0, m_uf});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_byte(input logic hi, input logic [7:0] d);
    @(negedge clk);
    bus_addr = hi; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input string tag, input logic word, input logic hi);
    @(negedge clk);
    bus_word = word; bus_addr = hi; bus_rd = 1;
    if (word)    exp_q.push_back(m_cnt);
    else if (hi) exp_q.push_back({8'h00, m_cnt[15:8]});
    else         exp_q.push_back({8'h00, m_sh});
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 0; bus_word = 0;
  endtask

  task automatic kick();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    #100_000;
    if (!done) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 16'h0000);
    check("R1 underflow in reset", {15'h0, underflow}, 16'h0000);
    rst_n = 1;
    idle(2);
    rd("R1 count zero", 1, 0);
    rd("R1 shadow zero", 0, 0);

    wr_byte(1, 8'h12);
    wr_byte(0, 8'h34);
    run_en = 1;
    kick();
    rd("R2 load then decrement", 1, 0);
    idle(5);
    rd("R2 decrement", 1, 1);
    rd("R4 high byte", 0, 1);
    idle(3);
    rd("R4 low from shadow", 0, 0);
    idle(2);
    rd("R5 stale shadow", 0, 0);

    wr_byte(1, 8'h00);
    wr_byte(0, 8'h04);
    rd("R3 count unaffected by write", 1, 0);

    run_en = 0;
    idle(3);
    rd("R9 hold", 1, 0);
    kick();
    rd("R9 start ignored", 1, 0);

    run_en = 1;
    kick();
    for (int i = 0; i < 14; i++) rd("R6 word read / R7 reload mode", 1, i[0]);

    oneshot = 1;
    kick();
    idle(12);
    rd("R8 one-shot holds reload", 1, 0);
    idle(4);
    rd("R8 still held", 1, 1);
    rd("R4 high after one-shot", 0, 1);
    rd("R4 low after one-shot", 0, 0);

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule